// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the 16-bit operand address of an 8-bit processor core for the extended mode and for seven indexed variations. Five of the indexed variations take the concatenated H:X index pair as their base and two take the stack pointer. The decoder raises a one-cycle start pulse together with a mode code. The operand bytes that follow the opcode then arrive one per cycle, high byte first, qualified by a byte-valid input. Idle cycles between bytes are allowed.

When the last required byte has been taken, the block registers the address and raises a one-cycle valid strobe. Modes with no operand bytes produce the address one cycle after start. In the two post-increment modes the block keeps the index value it used. When the memory side reports that the operand fetch is complete, the block returns that value plus one together with a one-cycle write enable. A new start is not accepted until that write-back has happened.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (extended) takes two operand bytes, and the address is {first byte, second byte}.
- R2: Mode codes 1 (index, plain) and 2 (index, post-increment) take no operand bytes, and the address equals the H:X input.
- R3: Mode codes 3 (index + 8-bit), 4 (index + 8-bit, post-increment) and 6 (stack + 8-bit) take one byte. That byte is zero-extended and added to H:X (codes 3 and 4) or to the stack pointer (code 6).
- R4: Mode codes 5 (index + 16-bit) and 7 (stack + 16-bit) take two bytes, high byte first. The 16-bit value is added to H:X (code 5) or to the stack pointer (code 7).
- R5: All address sums and the index increment wrap modulo 65536.
- R6: `ea_vld` goes high for one cycle, in the cycle after the clock edge that accepted the last operand byte. For modes with no operand bytes it goes high in the cycle after the start edge. Idle cycles between bytes delay it without changing the result.
- R7: In codes 2 and 4, the address uses H:X before the increment. One cycle after `fetch_done` is sampled high, `hx_we` pulses for one cycle with `hx_new` equal to the base H:X plus 1.
- R8: `hx_we` never rises in the other modes, and `fetch_done` has no effect when no write-back is pending.
- R9: `start` is ignored while operand bytes are being collected and while a post-increment write-back is pending.
- R10: A synchronous reset returns the block to idle, clears `ea_vld` and `hx_we`, and drops any pending write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins an address computation |
| mode | input | 3 | Addressing mode code, sampled with start |
| byte_vld | input | 1 | Qualifies byte_in |
| byte_in | input | BW | Operand byte from program memory |
| hx | input | AW | H:X index pair |
| sp | input | AW | Stack pointer |
| fetch_done | input | 1 | The operand fetch for the presented address is complete |
| ea | output | AW | Effective address, registered |
| ea_vld | output | 1 | Strobe for ea |
| hx_new | output | AW | Incremented index pair |
| hx_we | output | 1 | Write enable for hx_new |

## Verification
The bench builds the block with its default 16-bit address and 8-bit byte, and with the byte-lane adder variant selected. That adder splits every sum into two carry-linked lanes, so offsets are chosen to carry from the low lane into the high lane and to wrap out of the top lane. Post-increment is driven from 0xFFFF, and starts and resets are injected in the middle of byte collection and during a pending write-back.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      M_EXT  = 3'd0,
      M_IX   = 3'd1,
      M_IXP  = 3'd2,
      M_IX1  = 3'd3,
      M_IX1P = 3'd4,
      M_IX2  = 3'd5,
      M_SP1  = 3'd6,
      M_SP2  = 3'd7
   } ea_mode_e;

   // operand bytes a mode consumes after the opcode
   function automatic int unsigned opnd_bytes(ea_mode_e m);
      case (m)
         M_IX, M_IXP:                 return 0;
         M_IX1, M_IX1P, M_SP1:        return 1;
         default:                     return 2;
      endcase
   endfunction

   function automatic logic is_post(ea_mode_e m);
      return (m == M_IXP) || (m == M_IX1P);
   endfunction

   function automatic logic is_sp(ea_mode_e m);
      return (m == M_SP1) || (m == M_SP2);
   endfunction

endpackage

// File: rtl/ea_opnd_asm.sv
module ea_opnd_asm
   import ea_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  ea_mode_e      mode_i,
   input  logic          byte_vld,
   input  logic [BW-1:0] byte_in,
   output logic          done,
   output logic [AW-1:0] opnd,
   output ea_mode_e      mode_cur,
   output ea_mode_e      mode_q
);
   localparam int NB = AW / BW;
   localparam int CW = $clog2(NB + 1);

   typedef enum logic {S_IDLE, S_COLLECT} st_e;

   st_e           st_q;
   logic [CW-1:0] need_q, cnt_q, cnt_nx, need_in;
   logic [AW-1:0] shreg_q, shifted;
   logic          acc;

   assign need_in  = CW'(opnd_bytes(mode_i));
   assign acc      = byte_vld && (st_q == S_COLLECT);
   assign cnt_nx   = cnt_q + CW'(1);
   assign shifted  = {shreg_q[AW-BW-1:0], byte_in};
   assign opnd     = acc ? shifted : shreg_q;
   assign mode_cur = (st_q == S_IDLE) ? mode_i : mode_q;
   assign done     = ((st_q == S_IDLE) && start && (need_in == '0)) ||
                     (acc && (cnt_nx == need_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         need_q  <= '0;
         shreg_q <= '0;
         mode_q  <= M_EXT;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  mode_q  <= mode_i;
                  need_q  <= need_in;
                  cnt_q   <= '0;
                  shreg_q <= '0;
                  if (need_in != '0) st_q <= S_COLLECT;
               end
            end
            default: begin
               if (acc) begin
                  shreg_q <= shifted;
                  cnt_q   <= cnt_nx;
                  if (cnt_nx == need_q) st_q <= S_IDLE;
               end
            end
         endcase
      end
   end

   // the byte counter stays below the byte count of the latched mode
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_COLLECT) |-> (cnt_q < need_q));

   // a start seen while collecting leaves the latched mode untouched
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      ((st_q == S_COLLECT) && !acc) |=> $stable(mode_q));

endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int AW        = 16,
   parameter int BW        = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  ea_mode_e      mode,
   input  logic [AW-1:0] opnd,
   input  logic [AW-1:0] hx,
   input  logic [AW-1:0] sp,
   output logic [AW-1:0] ea
);
   localparam int NL = AW / BW;

   logic [AW-1:0] base, off, sum;

   always_comb begin
      base = is_sp(mode) ? sp : hx;
      case (mode)
         M_IX, M_IXP:                 off = '0;
         M_IX1, M_IX1P, M_SP1:        off = {{(AW-BW){1'b0}}, opnd[BW-1:0]};
         default:                     off = opnd;
      endcase
   end

   generate
      if (!SPLIT_ADD) begin : g_flat
         assign sum = base + off;
      end else begin : g_lanes
         logic [NL-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar g = 0; g < NL; g++) begin : g_lane
            if (g < NL - 1) begin : g_mid
               assign {cy[g+1], sum[g*BW +: BW]} =
                  {1'b0, base[g*BW +: BW]} + {1'b0, off[g*BW +: BW]} + (BW+1)'(cy[g]);
            end else begin : g_top
               assign sum[g*BW +: BW] =
                  base[g*BW +: BW] + off[g*BW +: BW] + BW'(cy[g]);
            end
         end
      end
   endgenerate

   assign ea = (mode == M_EXT) ? opnd : sum;

endmodule

// File: rtl/ea_postinc.sv
module ea_postinc #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          arm,
   input  logic [AW-1:0] hx_in,
   input  logic          fetch_done,
   output logic          pending,
   output logic          hx_we,
   output logic [AW-1:0] hx_new
);
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending <= 1'b0;
         hx_we   <= 1'b0;
         hx_new  <= '0;
         base_q  <= '0;
      end else begin
         hx_we <= 1'b0;
         if (arm) begin
            pending <= 1'b1;
            base_q  <= hx_in;
         end else if (pending && fetch_done) begin
            pending <= 1'b0;
            hx_we   <= 1'b1;
            hx_new  <= base_q + AW'(1);
         end
      end
   end

   p_we_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      hx_we |=> !hx_we);

   p_we_cause_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(hx_we) |-> $past(pending && fetch_done));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int AW        = 16,
   parameter int BW        = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [2:0]    mode,
   input  logic          byte_vld,
   input  logic [BW-1:0] byte_in,
   input  logic [AW-1:0] hx,
   input  logic [AW-1:0] sp,
   input  logic          fetch_done,
   output logic [AW-1:0] ea,
   output logic          ea_vld,
   output logic [AW-1:0] hx_new,
   output logic          hx_we
);
   generate
      if (AW != 2 * BW) begin : g_bad_width
         $error("ea_unit: AW must be twice BW");
      end
      if (BW < 2) begin : g_bad_byte
         $error("ea_unit: BW too small");
      end
   endgenerate

   logic          done, pend, start_ok;
   logic [AW-1:0] opnd, ea_nx;
   ea_mode_e      mode_cur, mode_q;

   assign start_ok = start && !pend;

   ea_opnd_asm #(.AW(AW), .BW(BW)) u_asm (
      .clk      (clk),
      .rst      (rst),
      .start    (start_ok),
      .mode_i   (ea_mode_e'(mode)),
      .byte_vld (byte_vld),
      .byte_in  (byte_in),
      .done     (done),
      .opnd     (opnd),
      .mode_cur (mode_cur),
      .mode_q   (mode_q)
   );

   ea_calc #(.AW(AW), .BW(BW), .SPLIT_ADD(SPLIT_ADD)) u_calc (
      .mode (mode_cur),
      .opnd (opnd),
      .hx   (hx),
      .sp   (sp),
      .ea   (ea_nx)
   );

   ea_postinc #(.AW(AW)) u_inc (
      .clk        (clk),
      .rst        (rst),
      .arm        (done && is_post(mode_cur)),
      .hx_in      (hx),
      .fetch_done (fetch_done),
      .pending    (pend),
      .hx_we      (hx_we),
      .hx_new     (hx_new)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ea_vld <= 1'b0;
         ea     <= '0;
      end else begin
         ea_vld <= done;
         if (done) ea <= ea_nx;
      end
   end

   p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!ea_vld && !hx_we));

   p_no_start_pending_r9: assert property (@(posedge clk) disable iff (rst)
      pend |-> !done);

   // plain post-increment: the written value sits one above the address used
   p_pre_inc_addr_r7: assert property (@(posedge clk) disable iff (rst)
      (hx_we && (mode_q == M_IXP)) |-> (hx_new == ea + AW'(1)));

endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
   localparam int AW = 16;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [2:0]    md = 3'd0;
   logic          byte_vld = 1'b0;
   logic [BW-1:0] byte_in = '0;
   logic [AW-1:0] hx = '0;
   logic [AW-1:0] sp = '0;
   logic          fetch_done = 1'b0;
   logic [AW-1:0] ea, hx_new;
   logic          ea_vld, hx_we;

   always #5 clk = ~clk;

   ea_unit #(.AW(AW), .BW(BW), .SPLIT_ADD(1'b1)) u0 (
      .clk(clk), .rst(rst), .start(start), .mode(md), .byte_vld(byte_vld),
      .byte_in(byte_in), .hx(hx), .sp(sp), .fetch_done(fetch_done),
      .ea(ea), .ea_vld(ea_vld), .hx_new(hx_new), .hx_we(hx_we)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [AW-1:0] ea_q[$];
   string         ea_tag[$];
   logic [AW-1:0] wb_q[$];
   string         wb_tag[$];

   task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   // monitor: pops the scoreboard whenever the design produces a result
   always @(negedge clk) begin
      if (!rst) begin
         if (ea_vld) begin
            if (ea_q.size() == 0) chk(1'b0, "R6 unexpected ea_vld", ea, '0);
            else begin
               automatic logic [AW-1:0] e = ea_q.pop_front();
               automatic string t = ea_tag.pop_front();
               chk(ea == e, t, ea, e);
            end
         end
         if (hx_we) begin
            if (wb_q.size() == 0) chk(1'b0, "R8 unexpected hx_we", hx_new, '0);
            else begin
               automatic logic [AW-1:0] e = wb_q.pop_front();
               automatic string t = wb_tag.pop_front();
               chk(hx_new == e, t, hx_new, e);
            end
         end
      end
   end

   function automatic int nbytes(input int m);
      case (m)
         1, 2:    return 0;
         3, 4, 6: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic logic [AW-1:0] model(input int m, input logic [AW-1:0] v,
                                           input logic [AW-1:0] h, input logic [AW-1:0] s);
      case (m)
         0:       return v;
         1, 2:    return h;
         3, 4:    return h + {8'h00, v[7:0]};
         5:       return h + v;
         6:       return s + {8'h00, v[7:0]};
         default: return s + v;
      endcase
   endfunction

   // driver: pushes expectations, then plays the operation
   task automatic do_op(input int m, input logic [AW-1:0] v, input logic [AW-1:0] h,
                        input logic [AW-1:0] s, input int gap, input bit skip_fetch,
                        input string tag);
      automatic int n = nbytes(m);
      automatic bit post = (m == 2) || (m == 4);
      ea_q.push_back(model(m, v, h, s));
      ea_tag.push_back({tag, " ea value"});
      if (post && !skip_fetch) begin
         wb_q.push_back(h + 16'd1);
         wb_tag.push_back({tag, " R7 hx_new"});
      end
      @(negedge clk);
      md = 3'(m); hx = h; sp = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         repeat (gap) @(negedge clk);
         byte_vld = 1'b1;
         byte_in  = (n == 2 && i == 0) ? v[15:8] : v[7:0];
         @(negedge clk);
         byte_vld = 1'b0;
      end
      chk(ea_vld == 1'b1, {tag, " R6 strobe timing"}, {15'd0, ea_vld}, 16'd1);
      if (skip_fetch) return;
      @(negedge clk);
      chk(ea_vld == 1'b0, {tag, " R6 strobe width"}, {15'd0, ea_vld}, 16'd0);
      if (post) begin
         chk(hx_we == 1'b0, {tag, " R7 no early write"}, {15'd0, hx_we}, 16'd0);
         fetch_done = 1'b1;
         @(negedge clk);
         fetch_done = 1'b0;
         chk(hx_we == 1'b1, {tag, " R7 write strobe"}, {15'd0, hx_we}, 16'd1);
         @(negedge clk);
         chk(hx_we == 1'b0, {tag, " R7 write width"}, {15'd0, hx_we}, 16'd0);
      end else begin
         fetch_done = 1'b1;
         @(negedge clk);
         fetch_done = 1'b0;
         chk(hx_we == 1'b0, {tag, " R8 no write"}, {15'd0, hx_we}, 16'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ea_vld == 1'b0 && hx_we == 1'b0, "R10 reset outputs", {14'd0, ea_vld, hx_we}, 16'd0);
      rst = 1'b0;

      do_op(0, 16'hBEEF, 16'h1111, 16'h2222, 0, 1'b0, "R1 ext");
      do_op(0, 16'h0001, 16'h1111, 16'h2222, 2, 1'b0, "R1 R6 ext gaps");
      do_op(1, 16'h0000, 16'h1234, 16'h0000, 0, 1'b0, "R2 ix");
      do_op(3, 16'h00FF, 16'h1000, 16'h0000, 0, 1'b0, "R3 ix1 unsigned");
      do_op(6, 16'h0080, 16'h0000, 16'h0180, 1, 1'b0, "R3 sp1 carry");
      do_op(5, 16'h2345, 16'h1000, 16'h0000, 0, 1'b0, "R4 ix2");
      do_op(7, 16'h12F0, 16'hAAAA, 16'h0120, 3, 1'b0, "R4 sp2");
      do_op(7, 16'hFF00, 16'h0000, 16'h0100, 0, 1'b0, "R5 sp2 wrap");
      do_op(5, 16'h2000, 16'hF000, 16'h0000, 0, 1'b0, "R5 ix2 wrap");
      do_op(3, 16'h0020, 16'hFFF0, 16'h0000, 0, 1'b0, "R5 ix1 wrap");
      do_op(2, 16'h0000, 16'h2000, 16'h0000, 0, 1'b0, "R7 ix+");
      do_op(4, 16'h0010, 16'h3000, 16'h0000, 1, 1'b0, "R7 ix1+");
      do_op(2, 16'h0000, 16'hFFFF, 16'h0000, 0, 1'b0, "R5 R7 ix+ wrap");

      // R8: fetch_done while idle
      @(negedge clk); fetch_done = 1'b1;
      @(negedge clk); fetch_done = 1'b0;
      chk(hx_we == 1'b0, "R8 idle fetch_done", {15'd0, hx_we}, 16'd0);

      // R9: start during byte collection is dropped
      ea_q.push_back(16'hC0DE); ea_tag.push_back("R9 collect ea value");
      @(negedge clk); md = 3'd0; start = 1'b1;
      @(negedge clk); start = 1'b0; byte_vld = 1'b1; byte_in = 8'hC0;
      @(negedge clk); byte_vld = 1'b0; md = 3'd1; hx = 16'h5555; start = 1'b1;
      @(negedge clk); start = 1'b0; byte_vld = 1'b1; byte_in = 8'hDE;
      @(negedge clk); byte_vld = 1'b0;
      chk(ea_vld == 1'b1, "R9 collect strobe", {15'd0, ea_vld}, 16'd1);
      repeat (3) begin
         @(negedge clk);
         chk(ea_vld == 1'b0, "R9 no extra result", {15'd0, ea_vld}, 16'd0);
      end

      // R9: start while a write-back is pending is dropped
      do_op(2, 16'h0000, 16'h4000, 16'h0000, 0, 1'b1, "R9 pend");
      wb_q.push_back(16'h4001); wb_tag.push_back("R9 pend R7 hx_new");
      md = 3'd1; hx = 16'h7777; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk(ea_vld == 1'b0, "R9 pending start dropped", {15'd0, ea_vld}, 16'd0);
      fetch_done = 1'b1;
      @(negedge clk); fetch_done = 1'b0;
      chk(hx_we == 1'b1, "R9 pend R7 write strobe", {15'd0, hx_we}, 16'd1);

      // R10: reset during collection returns to idle
      @(negedge clk); md = 3'd0; start = 1'b1;
      @(negedge clk); start = 1'b0; byte_vld = 1'b1; byte_in = 8'h12;
      @(negedge clk); byte_vld = 1'b0; rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(ea_vld == 1'b0 && hx_we == 1'b0, "R10 mid-op reset", {14'd0, ea_vld, hx_we}, 16'd0);
      do_op(1, 16'h0000, 16'h0ABC, 16'h0000, 0, 1'b0, "R10 idle after reset");

      // R10: reset drops a pending write-back
      do_op(4, 16'h0001, 16'h0100, 16'h0000, 0, 1'b1, "R10 pend");
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0; fetch_done = 1'b1;
      @(negedge clk); fetch_done = 1'b0;
      chk(hx_we == 1'b0, "R10 pending dropped", {15'd0, hx_we}, 16'd0);

      repeat (2) @(negedge clk);
      chk(ea_q.size() == 0 && wb_q.size() == 0, "R6 R7 scoreboard drained",
          16'(ea_q.size() + wb_q.size()), 16'd0);
      summary();
      $finish;
   end
endmodule